// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock and open-drain data) that gives a host read and write access to a small bank of 8-bit control registers. It watches the already-sampled bus lines, runs in the system clock domain, recognises its own fixed device address, and then takes a command byte. That byte picks the register index and chooses between single-register access and counted block access. The only thing it puts back on the bus is an enable for the data-line pull-down.

In block writes the first data byte is a length. Up to that many bytes are then stored at rising indexes. In block reads the slave first returns the length held in the count register and then returns registers from the chosen index upward, each byte most significant bit first. A transfer may stop after any complete byte. Registers already written keep their new values, and a byte cut short never lands.

Each stored byte also appears for one cycle on a write-strobe port, and the whole register bank is brought out as a flat vector for the logic it controls.

Top module: `smbr_top`

## Requirements
- R1: The slave acknowledges the address byte 0xD6 (write) and 0xD7 (read). For any other address byte it never pulls the data line, and it ignores the bus until the next start condition.
- R2: After reset the registers hold 0x04, 0x05, 0xC0, 0x08, 0x06, 0xD8 at indexes 0 to 5.
- R3: A command byte with bit 7 set selects single-byte mode with index = bits 6:0. A byte write stores the first data byte at that index. Any further data bytes are acknowledged and discarded.
- R4: A command byte with bit 7 clear selects block mode with start index = bits 6:0. The first data byte of a block write is a length L and is not stored. The next L bytes go to consecutive indexes, and bytes beyond L are acknowledged and discarded.
- R5: A block read, after the write-form address, command byte, repeated start and read-form address, first returns the value of register 4 and then returns registers from the start index upward. It stops driving when the host answers a byte with a NACK.
- R6: A single-byte read (command bit 7 set, then repeated start and read-form address) returns the register at the chosen index, most significant bit first.
- R7: A stop after any complete byte leaves all earlier stored bytes in place. A byte that is interrupted by a stop before its 8th bit is never stored.
- R8: Writes to an index of 6 or higher are acknowledged but change no register. Reads of such an index return 0x00.
- R9: The slave changes its data-line pull-down only while the clock line is low.
- R10: Each data byte accepted by the framing produces a one-cycle write strobe carrying its index and value. An in-range strobe appears in the register bank on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| wr_stb_o | output | 1 | One-cycle strobe per framed data byte |
| wr_idx_o | output | 7 | Register index of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |
| ctrl_regs_o | output | 48 | Register bank, index 0 in bits 7:0 |

## Verification
The assertions assume a well-behaved single host. That host moves the data line only while the clock line is low, except when it makes a start or stop. It keeps each clock phase well longer than the three-flop synchroniser delay, and it never makes a start or stop while the slave is driving. The bench models the bus as a wired-AND of the host and the slave pull-down. It holds every clock half-period at ten system clocks and changes its lines on the falling system edge, so every edge reaches the slave clean and in order.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  localparam int unsigned IDXW = 7;
  localparam logic [6:0] DEV_ADDR7 = 7'b1101011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } rx_phase_t;

  function automatic logic is_dev_addr(input logic [7:0] b);
    return b[7:1] == DEV_ADDR7;
  endfunction

  function automatic logic is_single_mode(input logic [7:0] cmd);
    return cmd[7];
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      0: return 8'h04;
      1: return 8'h05;
      2: return 8'hC0;
      3: return 8'h08;
      4: return 8'h06;
      5: return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbr_linesync.sv
module smbr_linesync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_s     = scl_p[1];
  assign sda_s     = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

endmodule

// File: rtl/smbr_regbank.sv
module smbr_regbank #(
  parameter int unsigned NREG = 6,
  parameter int unsigned IDXW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  regs_flat
);
  import smbr_pkg::*;

  localparam logic [IDXW-1:0] NREG_I = IDXW'(NREG);

  logic [7:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[i] <= reset_value(i);
      else if (wr_en && wr_idx == IDXW'(i))
        regs_q[i] <= wr_data;
    end
    assign regs_flat[i*8 +: 8] = regs_q[i];

    // R10: an in-range strobe lands in the addressed register next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDXW'(i)) |=> regs_q[i] == $past(wr_data));
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDXW'(i)) rd_data = regs_q[i];
  end

  // R8: out-of-range writes leave the whole bank unchanged
  a_r8_oob_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= NREG_I) |=> $stable(regs_flat));

endmodule

// File: rtl/smbr_protocol.sv
module smbr_protocol #(
  parameter int unsigned IDXW    = 7,
  parameter int unsigned CNT_IDX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_stb,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_pull
);
  import smbr_pkg::*;

  localparam logic [IDXW-1:0] CNT_IDX_I = IDXW'(CNT_IDX);

  bus_state_t      state;
  rx_phase_t       phase;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, txsh, remain;
  logic [IDXW-1:0] ptr;
  logic            rd_mode, blk_mode, cnt_phase, single_done, send_cnt;

  assign rd_idx = send_cnt ? CNT_IDX_I : ptr;

  wire byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  wire data_take = blk_mode ? (remain != 8'h00) : !single_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= PH_ADDR;
      bitcnt      <= 4'd0;
      shreg       <= 8'h00;
      txsh        <= 8'h00;
      remain      <= 8'h00;
      ptr         <= '0;
      rd_mode     <= 1'b0;
      blk_mode    <= 1'b0;
      cnt_phase   <= 1'b0;
      single_done <= 1'b0;
      send_cnt    <= 1'b0;
      sda_pull    <= 1'b0;
      wr_stb      <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= 8'h00;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= ST_RX;
        phase    <= PH_ADDR;
        bitcnt   <= 4'd0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              bitcnt <= 4'd0;
              unique case (phase)
                PH_ADDR: begin
                  if (is_dev_addr(shreg)) begin
                    rd_mode  <= shreg[0];
                    send_cnt <= shreg[0] & blk_mode;
                    sda_pull <= 1'b1;
                    state    <= ST_RXACK;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_CMD: begin
                  blk_mode    <= ~is_single_mode(shreg);
                  cnt_phase   <= ~is_single_mode(shreg);
                  ptr         <= shreg[IDXW-1:0];
                  single_done <= 1'b0;
                  sda_pull    <= 1'b1;
                  state       <= ST_RXACK;
                end
                default: begin
                  if (cnt_phase) begin
                    remain    <= shreg;
                    cnt_phase <= 1'b0;
                  end else if (data_take) begin
                    wr_stb      <= 1'b1;
                    wr_idx      <= ptr;
                    wr_data     <= shreg;
                    ptr         <= ptr + 1'b1;
                    remain      <= remain - 8'd1;
                    single_done <= 1'b1;
                  end
                  sda_pull <= 1'b1;
                  state    <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              if (rd_mode && phase == PH_ADDR) begin
                txsh     <= rd_data;
                sda_pull <= ~rd_data[7];
                if (send_cnt) send_cnt <= 1'b0;
                else          ptr      <= ptr + 1'b1;
                state <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                phase    <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt   <= 4'd0;
                sda_pull <= 1'b0;
                state    <= ST_TXACK;
              end else begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_pull <= ~txsh[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_IGNORE;
            end else if (scl_fall) begin
              txsh     <= rd_data;
              sda_pull <= ~rd_data[7];
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr      <= ptr + 1'b1;
              state <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the pull-down only moves while the clock line is low
  a_r9_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));

  // R1: a start always restarts address reception
  a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_RX && phase == PH_ADDR && bitcnt == 4'd0));

  // R1: an ignored transfer never pulls the data line
  a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE && $past(state == ST_IGNORE)) |-> !sda_pull);

  // R7: the bit counter never passes one whole byte
  a_r7_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

  // R10: a write strobe lasts exactly one cycle
  a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

endmodule

// File: rtl/smbr_top.sv
module smbr_top #(
  parameter int unsigned NREG    = 6,
  parameter int unsigned CNT_IDX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  output logic                wr_stb_o,
  output logic [6:0]          wr_idx_o,
  output logic [7:0]          wr_data_o,
  output logic [NREG*8-1:0]   ctrl_regs_o
);
  import smbr_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_data;

  smbr_linesync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbr_protocol #(.IDXW(IDXW), .CNT_IDX(CNT_IDX)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_stb    (wr_stb_o),
    .wr_idx    (wr_idx_o),
    .wr_data   (wr_data_o),
    .sda_pull  (sda_pull_o)
  );

  smbr_regbank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_stb_o),
    .wr_idx    (wr_idx_o),
    .wr_data   (wr_data_o),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (ctrl_regs_o)
  );

endmodule

// File: tb/sim_smbr_top.sv
`timescale 1ns/1ps
module sim_smbr_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_pull, wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;
  logic [47:0] regs;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  smbr_top u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .ctrl_regs_o(regs)
  );

  int checks = 0, fails = 0, stb_cnt = 0, viol = 0;
  logic finished = 1'b0;
  logic [7:0] model [6];

  always @(posedge clk) if (wr_stb) stb_cnt <= stb_cnt + 1;

  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_pull != prev_pull) viol <= viol + 1;
    prev_scl  <= m_scl;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H);
    m_sda = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H/2);
    ack = ~sda_line; hw(H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hw(H); m_scl = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); m_scl = 1'b0;
    end
    m_sda = host_ack ? 1'b0 : 1'b1; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    hw(1); m_sda = 1'b1;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 6; i++) chk(req, regs[i*8 +: 8], model[i]);
  endtask

  // stimulus vectors: {command, write value, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h80, 8'h5A, 8'h5A}, {8'h85, 8'h33, 8'h33}, {8'h89, 8'h77, 8'h00},
    {8'h82, 8'hFF, 8'hFF}, {8'h81, 8'h00, 8'h00}, {8'h83, 8'hA5, 8'hA5},
    {8'h84, 8'h03, 8'h03}, {8'h86, 8'h11, 8'h00}
  };

  initial begin
    logic ack;
    logic [7:0] rb;
    int s0;
    model = '{8'h04, 8'h05, 8'hC0, 8'h08, 8'h06, 8'hD8};
    hw(5); rst_n = 1'b1; hw(5);

    // R2: reset contents, bus released
    check_regs("R2");
    chk("R9", sda_pull, 1'b0);

    // R5: block read from index 0 at reset: count then six registers
    bus_start(); send_byte(8'hD6, ack); chk("R1", ack, 1'b1);
    send_byte(8'h00, ack);
    bus_start(); send_byte(8'hD7, ack); chk("R1", ack, 1'b1);
    recv_byte(1'b1, rb); chk("R5", rb, 8'h06);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i != 5, rb); chk("R5", rb, model[i]);
    end
    bus_stop();

    // R3 R6 R8: single-byte write then single-byte read, per vector
    for (int v = 0; v < 8; v++) begin
      bus_start(); send_byte(8'hD6, ack); send_byte(VEC[v][23:16], ack);
      send_byte(VEC[v][15:8], ack); chk("R8", ack, 1'b1); bus_stop();
      if (VEC[v][22:16] < 7'd6) model[VEC[v][22:16]] = VEC[v][15:8];
      bus_start(); send_byte(8'hD6, ack); send_byte(VEC[v][23:16], ack);
      bus_start(); send_byte(8'hD7, ack);
      recv_byte(1'b0, rb); bus_stop();
      chk("R6", rb, VEC[v][7:0]);
    end
    check_regs("R3");

    // R4 R10: block write index 1, length 2, one surplus byte
    s0 = stb_cnt;
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h01, ack); send_byte(8'h02, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    chk("R4", ack, 1'b1); bus_stop();
    model[1] = 8'h11; model[2] = 8'h22;
    check_regs("R4");
    chk("R10", stb_cnt - s0, 2);

    // R5: block read from index 1 returns count register (now 3) first
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h01, ack);
    bus_start(); send_byte(8'hD7, ack);
    recv_byte(1'b1, rb); chk("R5", rb, 8'h03);
    recv_byte(1'b1, rb); chk("R5", rb, 8'h11);
    recv_byte(1'b1, rb); chk("R5", rb, 8'h22);
    recv_byte(1'b0, rb); chk("R5", rb, 8'hA5);
    bus_stop();

    // R3: single-byte write with a second data byte
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h85, ack);
    send_byte(8'h44, ack); send_byte(8'h55, ack); chk("R3", ack, 1'b1); bus_stop();
    model[5] = 8'h44;
    check_regs("R3");

    // R7: stop after one data byte of a longer block
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h00, ack); send_byte(8'h04, ack);
    send_byte(8'h99, ack); bus_stop();
    model[0] = 8'h99;
    check_regs("R7");

    // R7: stop inside a data byte
    s0 = stb_cnt;
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h80, ack);
    send_bits(8'hA0, 4); bus_stop();
    check_regs("R7");
    chk("R7", stb_cnt - s0, 0);

    // R1: foreign address, all following bytes ignored
    bus_start(); send_byte(8'hA0, ack); chk("R1", ack, 1'b0);
    send_byte(8'h80, ack); chk("R1", ack, 1'b0);
    send_byte(8'h12, ack); chk("R1", ack, 1'b0); bus_stop();
    check_regs("R1");

    // R8 R10: block write running past the last register
    s0 = stb_cnt;
    bus_start(); send_byte(8'hD6, ack); send_byte(8'h05, ack); send_byte(8'h03, ack);
    send_byte(8'h61, ack); send_byte(8'h62, ack); send_byte(8'h63, ack);
    chk("R8", ack, 1'b1); bus_stop();
    model[5] = 8'h61;
    check_regs("R8");
    chk("R10", stb_cnt - s0, 3);
    chk("R10", wr_idx, 7'd7);
    chk("R10", wr_data, 8'h63);

    // R9: pull-down never moved while the clock line was high
    chk("R9", viol, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule